// File: doc/BRIEF.md
# Interrupt Request Arbiter

This block sits beside an 8-bit CPU core and chooses, at each instruction boundary, which pending interrupt request is taken. There are four request sources. One is non-maskable and latched on a falling edge. Three are maskable lines, numbered 0 to 2. The raw request pins are asynchronous and active low. Each pin passes through a two-flop synchronizer before any level test or edge test is applied.

Maskable line 0 is level-sensed. Its request is the OR of its pin and two internal peripheral sources. Lines 1 and 2 can each be set to level sensing or to edge sensing, and in edge mode each line can be set to react to a rising or a falling edge. When a request wins, the block starts an acknowledge cycle that lasts a fixed number of clock cycles. During that cycle it drives the granted source code, the fixed restart address for the non-maskable case, and the opcode-fetch and I/O-request acknowledge strobes. All pins are plain control and status signals: a grant is a reaction to the boundary pulse, and no handshake exists at the block's edge.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `ack_active`, `ack_m1` and `ack_iorq` are low, `restart_addr` is 0, and `pin_level` reads 2'b11.
- R2: A falling edge on `nmi_n` sets a latched non-maskable request. That request is taken at the next `instr_end` whatever the values of `int_en` and `bus_req`. A pin that is held low afterwards does not raise the request again.
- R3: While a non-maskable acknowledge is active, `restart_addr` is 16'h0066 and both strobes are low. During any other acknowledge, and while idle, `restart_addr` is 0.
- R4: Priority at a boundary is: non-maskable first, then line 0, then line 1, then line 2. `take_code` encodes these sources as 0, 1, 2 and 3 in that order.
- R5: The line 0 request is high while `irq0_n` is low or while either `per_irq_a` or `per_irq_b` is high. Any maskable line is taken only if `int_en` is 1 and `bus_req` is 0.
- R6: During a line 0 acknowledge, `ack_m1` and `ack_iorq` are both high for the whole acknowledge.
- R7: Lines 1 and 2 are taken only when no non-maskable request and no line 0 request is present. During their acknowledge both strobes stay low.
- R8: `edge_mode` bit 0 controls line 1 and bit 1 controls line 2; a value of 1 selects edge sensing. `edge_rise` uses the same bit order; 1 selects the rising edge and 0 the falling edge. A latched edge request survives boundaries at which it is blocked. It is cleared when its own acknowledge completes.
- R9: In level mode, lines 1 and 2 are not latched. A low pulse on the pin that has ended before the boundary is not taken.
- R10: `ack_active` rises in the cycle after the boundary and stays high for exactly ACK_LEN cycles, which is 4 by default. `take_code` stays stable during that time, and `instr_end` is ignored while an acknowledge is active.
- R11: `pin_level` bit 0 shows the synchronized level of `irq1_n` and bit 1 shows `irq2_n`. A pin change appears after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request pin, active low |
| irq0_n | input | 1 | Maskable line 0 pin, active low, level |
| irq1_n | input | 1 | Maskable line 1 pin, active low |
| irq2_n | input | 1 | Maskable line 2 pin, active low |
| per_irq_a | input | 1 | Internal peripheral source A, ORed into line 0 |
| per_irq_b | input | 1 | Internal peripheral source B, ORed into line 0 |
| instr_end | input | 1 | Instruction-boundary pulse |
| bus_req | input | 1 | Bus request; blocks the maskable lines |
| int_en | input | 1 | Maskable interrupt enable |
| edge_mode | input | 2 | Edge sensing enable for lines 1 and 2 |
| edge_rise | input | 2 | Edge polarity for lines 1 and 2 (1 = rising) |
| ack_active | output | 1 | Acknowledge cycle in progress |
| take_code | output | 2 | Granted source code |
| restart_addr | output | 16 | Restart address during a non-maskable acknowledge |
| ack_m1 | output | 1 | Opcode-fetch acknowledge strobe |
| ack_iorq | output | 1 | I/O-request acknowledge strobe |
| pin_level | output | 2 | Synchronized levels of lines 1 and 2 |

## Verification
Several request sources can be pending at the same boundary. The bench holds lines 1 and 2 low together, then adds line 0, then adds a non-maskable pulse. It judges the result by the code granted at each boundary and by the strobe pattern that code implies. A second cycle-level overlap occurs when a new boundary pulse arrives during an acknowledge. The bench drives that pulse mid-acknowledge and checks two things: the code stays fixed, and `ack_active` falls exactly ACK_LEN cycles after the original boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NMI = 2'd0,
    SRC_L0  = 2'd1,
    SRC_L1  = 2'd2,
    SRC_L2  = 2'd3
  } irq_src_e;
  localparam int NUM_SRC = 4;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic level_n,
  input  logic enable,
  input  logic rise_sel,
  input  logic clear,
  output logic pending
);
  logic prev_q;
  logic hit;

  always_comb begin
    if (rise_sel) hit = ~prev_q & level_n;
    else          hit = prev_q & ~level_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      prev_q <= level_n;
      if (enable && hit) pending <= 1'b1;
      else if (clear)    pending <= 1'b0;
    end
  end

  // R8: a latched request survives until its acknowledge completes
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !clear |=> pending);
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_arb_pkg::*;
#(
  parameter int          ACK_LEN = 4,
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] NMI_VEC = 16'h0066
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_nmi,
  input  logic              req_l0,
  input  logic              req_l1,
  input  logic              req_l2,
  input  logic              int_en,
  input  logic              bus_req,
  input  logic              instr_end,
  output logic              active,
  output irq_src_e          code,
  output logic              m1,
  output logic              iorq,
  output logic [ADDR_W-1:0] restart,
  output logic [NUM_SRC-1:0] done
);
  localparam int CNT_W = $clog2(ACK_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             win;
  irq_src_e         sel;
  logic             mask_ok;

  assign mask_ok = int_en & ~bus_req;

  always_comb begin
    win = 1'b1;
    sel = SRC_NMI;
    if (req_nmi)                 sel = SRC_NMI;
    else if (mask_ok && req_l0)  sel = SRC_L0;
    else if (mask_ok && req_l1)  sel = SRC_L1;
    else if (mask_ok && req_l2)  sel = SRC_L2;
    else                         win = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      code   <= SRC_NMI;
      cnt_q  <= '0;
    end else if (!active) begin
      if (instr_end && win) begin
        active <= 1'b1;
        code   <= sel;
        cnt_q  <= CNT_LAST;
      end
    end else if (cnt_q == '0) begin
      active <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    done = '0;
    if (active && cnt_q == '0) done[code] = 1'b1;
  end

  assign m1      = active && (code == SRC_L0);
  assign iorq    = active && (code == SRC_L0);
  assign restart = (active && code == SRC_NMI) ? ADDR_W'(NMI_VEC) : '0;

  // R10: an acknowledge only starts on a boundary pulse
  p_start_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(instr_end));
  // R5: maskable grants need enable set and bus request clear
  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) && code != SRC_NMI |-> $past(int_en && !bus_req));
  // R4: a pending non-maskable request always wins
  p_nmi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) && $past(req_nmi) |-> code == SRC_NMI);
  // R10: the granted code holds through the acknowledge
  p_code_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) |-> $stable(code));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int ACK_LEN     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic              irq0_n,
  input  logic              irq1_n,
  input  logic              irq2_n,
  input  logic              per_irq_a,
  input  logic              per_irq_b,
  input  logic              instr_end,
  input  logic              bus_req,
  input  logic              int_en,
  input  logic [1:0]        edge_mode,
  input  logic [1:0]        edge_rise,
  output logic              ack_active,
  output logic [1:0]        take_code,
  output logic [ADDR_W-1:0] restart_addr,
  output logic              ack_m1,
  output logic              ack_iorq,
  output logic [1:0]        pin_level
);
  localparam int NPIN = 4;

  logic [NPIN-1:0]    pins_s;
  logic [NUM_SRC-1:0] done;
  logic [2:0]         lat_pend;
  logic [2:0]         lat_lvl, lat_en, lat_rise, lat_clr;
  logic               req_l1, req_l2;
  irq_src_e           code;

  irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({irq2_n, irq1_n, irq0_n, nmi_n}),
    .dout (pins_s)
  );

  // latch slot 0: non-maskable, slots 1..2: lines 1..2
  assign lat_lvl  = {pins_s[3], pins_s[2], pins_s[0]};
  assign lat_en   = {edge_mode[1], edge_mode[0], 1'b1};
  assign lat_rise = {edge_rise[1], edge_rise[0], 1'b0};
  assign lat_clr  = {done[SRC_L2], done[SRC_L1], done[SRC_NMI]};

  for (genvar g = 0; g < 3; g++) begin : g_latch
    irq_edge_latch u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_n (lat_lvl[g]),
      .enable  (lat_en[g]),
      .rise_sel(lat_rise[g]),
      .clear   (lat_clr[g]),
      .pending (lat_pend[g])
    );
  end

  assign req_l1 = edge_mode[0] ? lat_pend[1] : ~pins_s[2];
  assign req_l2 = edge_mode[1] ? lat_pend[2] : ~pins_s[3];

  irq_ack_seq #(.ACK_LEN(ACK_LEN), .ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_nmi  (lat_pend[0]),
    .req_l0   (~pins_s[1] | per_irq_a | per_irq_b),
    .req_l1   (req_l1),
    .req_l2   (req_l2),
    .int_en   (int_en),
    .bus_req  (bus_req),
    .instr_end(instr_end),
    .active   (ack_active),
    .code     (code),
    .m1       (ack_m1),
    .iorq     (ack_iorq),
    .restart  (restart_addr),
    .done     (done)
  );

  assign take_code = code;
  assign pin_level = pins_s[3:2];

  // R6/R7: the two acknowledge strobes always move together
  p_strobe_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_m1 == ack_iorq);
  // R3: the restart address shows only during an acknowledge
  p_addr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_active |-> restart_addr == '0);
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int ACK_LEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1, irq0_n = 1'b1, irq1_n = 1'b1, irq2_n = 1'b1;
  logic per_irq_a = 1'b0, per_irq_b = 1'b0;
  logic instr_end = 1'b0, bus_req = 1'b0, int_en = 1'b1;
  logic [1:0] edge_mode = 2'b00, edge_rise = 2'b00;
  logic ack_active, ack_m1, ack_iorq;
  logic [1:0] take_code, pin_level;
  logic [15:0] restart_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_arbiter #(.ACK_LEN(ACK_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq0_n(irq0_n),
    .irq1_n(irq1_n), .irq2_n(irq2_n), .per_irq_a(per_irq_a),
    .per_irq_b(per_irq_b), .instr_end(instr_end), .bus_req(bus_req),
    .int_en(int_en), .edge_mode(edge_mode), .edge_rise(edge_rise),
    .ack_active(ack_active), .take_code(take_code),
    .restart_addr(restart_addr), .ack_m1(ack_m1), .ack_iorq(ack_iorq),
    .pin_level(pin_level)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // pulse instr_end; return at the negedge after the sampling edge
  task automatic boundary();
    instr_end = 1'b1;
    @(negedge clk);
    instr_end = 1'b0;
  endtask

  task automatic finish_ack();
    repeat (ACK_LEN) @(negedge clk);
  endtask

  task automatic expect_grant(string req, int code, int m1, int addr);
    boundary();
    chk(req, "ack_active", ack_active, 1);
    chk(req, "take_code", take_code, code);
    chk(req, "ack_m1", ack_m1, m1);
    chk(req, "ack_iorq", ack_iorq, m1);
    chk(req, "restart_addr", restart_addr, addr);
    finish_ack();
  endtask

  task automatic expect_none(string req);
    boundary();
    chk(req, "no grant", ack_active, 0);
  endtask

  task automatic t_reset();
    settle();
    chk("R1", "ack_active", ack_active, 0);
    chk("R1", "ack_m1", ack_m1, 0);
    chk("R1", "ack_iorq", ack_iorq, 0);
    chk("R1", "restart_addr", restart_addr, 0);
    chk("R1", "pin_level", pin_level, 3);
  endtask

  task automatic t_nmi();
    int_en = 1'b0; bus_req = 1'b1;
    nmi_n = 1'b0; settle();
    expect_grant("R2", 0, 0, 16'h0066);   // R3 address and strobes
    expect_none("R2");                    // held low: no new edge
    nmi_n = 1'b1; int_en = 1'b1; bus_req = 1'b0; settle();
  endtask

  task automatic t_line0();
    irq0_n = 1'b0; settle();
    expect_grant("R6", 1, 1, 0);          // R3: address 0 outside NMI
    bus_req = 1'b1; expect_none("R5");
    bus_req = 1'b0; int_en = 1'b0; expect_none("R5");
    int_en = 1'b1; irq0_n = 1'b1; settle();
    per_irq_a = 1'b1; expect_grant("R5", 1, 1, 0);
    per_irq_a = 1'b0; per_irq_b = 1'b1; expect_grant("R5", 1, 1, 0);
    per_irq_b = 1'b0; settle();
    expect_none("R5");
  endtask

  task automatic t_priority();
    irq1_n = 1'b0; irq2_n = 1'b0; settle();
    expect_grant("R4", 2, 0, 0);          // R7 strobes low
    irq0_n = 1'b0; settle();
    expect_grant("R4", 1, 1, 0);
    nmi_n = 1'b0; settle(); nmi_n = 1'b1; settle();
    expect_grant("R4", 0, 0, 16'h0066);
    irq0_n = 1'b1; settle();
    bus_req = 1'b1; expect_none("R7");
    bus_req = 1'b0; expect_grant("R7", 2, 0, 0);
    irq1_n = 1'b1; settle();
    expect_grant("R7", 3, 0, 0);
    irq2_n = 1'b1; settle();
  endtask

  task automatic t_level_pulse();
    edge_mode = 2'b00;
    irq1_n = 1'b0; settle(); irq1_n = 1'b1; settle();
    expect_none("R9");
  endtask

  task automatic t_edge();
    edge_mode = 2'b11; edge_rise = 2'b10;
    settle();
    irq1_n = 1'b0; settle(); irq1_n = 1'b1; settle();
    bus_req = 1'b1; expect_none("R8");
    bus_req = 1'b0; expect_grant("R8", 2, 0, 0);
    expect_none("R8");
    irq2_n = 1'b0; settle();
    expect_none("R8");                    // falling edge on rising-mode line
    irq2_n = 1'b1; settle();
    expect_grant("R8", 3, 0, 0);
    expect_none("R8");
    edge_mode = 2'b00; edge_rise = 2'b00; settle();
  endtask

  task automatic t_ack_len();
    irq0_n = 1'b0; settle();
    boundary();
    chk("R10", "start", ack_active, 1);
    instr_end = 1'b1;
    @(negedge clk);
    instr_end = 1'b0;
    chk("R10", "mid code", take_code, 1);
    chk("R10", "mid active", ack_active, 1);
    repeat (ACK_LEN - 2) @(negedge clk);
    chk("R10", "last cycle", ack_active, 1);
    @(negedge clk);
    chk("R10", "end", ack_active, 0);
    irq0_n = 1'b1; settle();
  endtask

  task automatic t_pins();
    irq1_n = 1'b0; irq2_n = 1'b1;
    @(negedge clk);
    chk("R11", "pin_level one edge", pin_level, 3);
    @(negedge clk);
    chk("R11", "pin_level two edges", pin_level, 2);
    irq1_n = 1'b1; irq2_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "pin_level line2", pin_level, 1);
    irq2_n = 1'b1; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nmi();
    t_line0();
    t_priority();
    t_level_pulse();
    t_edge();
    t_ack_len();
    t_pins();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule